// File: doc/BRIEF.md
# Conversion Instruction Sequencer with Result Queue

This block stores pre-loaded 12-bit conversion instructions and hands them one at a time to an external conversion engine. The host loads the instruction store and a small control word through a register port. It then issues an 8-bit command that either runs one chosen instruction once or starts a scan. A scan walks through the first N stored instructions in order and performs one conversion for each.

Every 24-bit result goes into an eight-entry queue that the host drains through a show-ahead read port. A completion flag tells the host when a scan, or a single conversion, has finished. In continuous mode the scan restarts from the first instruction, but only once the host has emptied the queue. Otherwise the block returns to idle and waits for the next command.

The conversion engine is abstract. It sees a one-cycle start pulse together with a channel number and an options field. It answers with a done strobe and the result word.

Top module: `conv_sequencer`

## Requirements
- R1: The instruction store is written as 24-bit words at addresses 0 to 3. Address a holds instruction 2a+1 in bits [11:0] and instruction 2a+2 in bits [23:12]. Address 4 is the control word: bits [2:0] hold the scan length minus one, and bit [3] selects continuous scanning. Every written address reads back its stored value, and unused control bits read as 0.
- R2: In an instruction, bits [1:0] name the input channel and bits [11:2] are the options (word rate, gain range, polarity). While `conv_start` is high, `conv_chan` and `conv_opts` carry those two fields of the instruction being run.
- R3: A command is accepted only when all of the following hold: the block is idle, `cmd_valid` is high, bit 7 of the command is 1, and bits [2:0] are 0. Any other command is ignored: `busy` stays low and no conversion starts. A conversion in progress is not disturbed.
- R4: A command with bit 6 = 0 runs the single instruction whose number minus one is in bits [5:3]. Its result becomes the only queue entry, the completion flag is raised, and the block returns to idle.
- R5: A command with bit 6 = 1 runs instructions 1 through (scan length) in order, one conversion each. The results are queued in conversion order, and the queue never overflows.
- R6: `conv_start` is a one-cycle pulse. It is issued in the cycle after a command is accepted, and in the cycle after each `conv_done` that is not the last of the run.
- R7: `rd_data` shows the oldest queued result. `rd_en` removes that entry, and `rd_en` on an empty queue has no effect. Accepting a new command discards any unread entries.
- R8: The completion flag rises in the cycle after the last result is queued. It clears on the first read from the queue or when a new command is accepted. If a read and a completion happen in the same cycle, the flag is set.
- R9: With continuous scanning, a finished scan waits, still busy and issuing no conversion, until the queue is empty, and then restarts at instruction 1. If the continuous bit is cleared while the block waits, it returns to idle.
- R10: After reset the block is idle, the queue is empty, the completion flag is low, and every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (0..3 instructions, 4 control) |
| reg_wdata | input | 24 | Register write data |
| reg_rdata | output | 24 | Register read data at `reg_addr` |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 8 | Command word |
| conv_start | output | 1 | Start pulse to the conversion engine |
| conv_chan | output | 2 | Channel of the running instruction |
| conv_opts | output | 10 | Options of the running instruction |
| conv_done | input | 1 | Conversion finished strobe |
| conv_data | input | 24 | Conversion result |
| rd_en | input | 1 | Pop the oldest result |
| rd_data | output | 24 | Oldest queued result |
| fifo_empty | output | 1 | Queue holds no result |
| scan_done | output | 1 | Run-complete flag |
| busy | output | 1 | A run is in progress or waiting to repeat |

## Verification
The bench sends commands while a conversion is still running. A design that accepted them would restart the run or corrupt the index. It also starts a new command while results are still unread, to catch a queue that keeps stale entries ahead of the new result.

In continuous mode the host drains the queue slowly. A design that restarted before the queue was empty would interleave two scans or overflow. Clearing the continuous bit during the wait must return the block to idle instead of leaving it stuck.

Reads on an empty queue, commands with a clear go bit, and commands with nonzero reserved bits must change nothing. A scan of the full length is also run, to check the full-queue boundary and the last-index compare.

// File: rtl/cseq_pkg.sv
// Shared constants and types for the conversion instruction sequencer.
// Assumes an 8-bit command word and 12-bit instructions.
package cseq_pkg;
    localparam int SETUP_W      = 12;
    localparam int CMD_W        = 8;
    localparam int CMD_GO_BIT   = 7;
    localparam int CMD_SCAN_BIT = 6;
    localparam int CMD_PTR_LSB  = 3;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_ISSUE = 2'd1,
        SQ_WAIT  = 2'd2,
        SQ_HOLD  = 2'd3
    } sq_state_t;
endpackage

// File: rtl/cseq_setup_store.sv
// Instruction store and control word. Two instructions share each
// register word (lower half = odd-numbered instruction); the control
// word follows the last pair. Assumes NUM_SETUP is even.
module cseq_setup_store
    import cseq_pkg::*;
#(
    parameter int NUM_SETUP = 8,
    parameter int ADDR_W    = 3,
    parameter int IDX_W     = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [2*SETUP_W-1:0]   wdata,
    output logic [2*SETUP_W-1:0]   rdata,
    input  logic [IDX_W-1:0]       sel_idx,
    output logic [SETUP_W-1:0]     sel_setup,
    output logic [IDX_W-1:0]       depth_m1,
    output logic                   loop_en
);
    localparam int NUM_REG   = NUM_SETUP / 2;
    localparam int CTRL_ADDR = NUM_REG;
    localparam int RD_W      = 2 * SETUP_W;

    logic [SETUP_W-1:0] setup_q [NUM_SETUP];
    logic [RD_W-1:0]    pair_word [NUM_REG];
    logic [IDX_W-1:0]   depth_q;
    logic               loop_q;

    // Instruction pair registers: load both halves of the addressed word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SETUP; i++) setup_q[i] <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < NUM_REG; i++) begin
                if (addr == ADDR_W'(i)) begin
                    setup_q[2*i]   <= wdata[SETUP_W-1:0];
                    setup_q[2*i+1] <= wdata[RD_W-1:SETUP_W];
                end
            end
        end
    end

    // Control word register: scan length minus one and continuous bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            depth_q <= '0;
            loop_q  <= 1'b0;
        end else if (wr_en && addr == ADDR_W'(CTRL_ADDR)) begin
            depth_q <= wdata[IDX_W-1:0];
            loop_q  <= wdata[IDX_W];
        end
    end

    // Rebuild each stored word from its two instruction halves.
    generate
        for (genvar g = 0; g < NUM_REG; g++) begin : g_pair
            assign pair_word[g] = {setup_q[2*g+1], setup_q[2*g]};
        end
    endgenerate

    // Readback multiplexer over instruction words and the control word.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_REG; i++) begin
            if (addr == ADDR_W'(i)) rdata = pair_word[i];
        end
        if (addr == ADDR_W'(CTRL_ADDR)) rdata = RD_W'({loop_q, depth_q});
    end

    assign sel_setup = setup_q[sel_idx];
    assign depth_m1  = depth_q;
    assign loop_en   = loop_q;

    // R1: a control write lands in the scan-length field one cycle later.
    a_r1_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(CTRL_ADDR)) |=> (depth_m1 == $past(wdata[IDX_W-1:0])));
endmodule

// File: rtl/cseq_fifo.sv
// Result queue with show-ahead output. A synchronous clear empties it
// and takes priority over push and pop. Pop on empty is ignored.
module cseq_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wptr_q, rptr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             full, do_pop, do_push;

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign dout    = mem[rptr_q];

    // Storage write at the tail.
    always_ff @(posedge clk) begin
        if (do_push && !clr) mem[wptr_q] <= din;
    end

    // Pointer and occupancy update with wrap at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (do_push) wptr_q <= (wptr_q == PTR_W'(DEPTH-1)) ? '0 : wptr_q + PTR_W'(1);
            if (do_pop)  rptr_q <= (rptr_q == PTR_W'(DEPTH-1)) ? '0 : rptr_q + PTR_W'(1);
            cnt_q <= cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    // R5: the sequencer never pushes into a full queue without a pop.
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (!full || pop));
    // R7: a clear leaves the queue empty.
    a_r7_clr_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> empty);
    // R7: occupancy stays within the depth.
    a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DEPTH));
endmodule

// File: rtl/cseq_fsm.sv
// Run controller: accepts commands while idle, issues one start per
// instruction, pushes each result, raises the completion flag, and in
// continuous mode waits for an empty queue before repeating.
module cseq_fsm
    import cseq_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd_code,
    input  logic [IDX_W-1:0] depth_m1,
    input  logic             loop_en,
    input  logic             conv_done,
    input  logic             fifo_empty,
    input  logic             rd_en,
    output logic             conv_start,
    output logic [IDX_W-1:0] idx,
    output logic             fifo_push,
    output logic             fifo_clr,
    output logic             scan_done,
    output logic             busy
);
    sq_state_t        state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic             scan_q, scan_d;
    logic             done_q;
    logic             accept, is_last, pop_ok;

    assign accept  = (state_q == SQ_IDLE) && cmd_valid && cmd_code[CMD_GO_BIT]
                     && (cmd_code[CMD_PTR_LSB-1:0] == '0);
    assign is_last = !scan_q || (idx_q == depth_m1);
    assign pop_ok  = rd_en && !fifo_empty && !accept;

    // Next-state and instruction index selection.
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        scan_d  = scan_q;
        unique case (state_q)
            SQ_IDLE: begin
                if (accept) begin
                    state_d = SQ_ISSUE;
                    scan_d  = cmd_code[CMD_SCAN_BIT];
                    idx_d   = cmd_code[CMD_SCAN_BIT] ? '0 : cmd_code[CMD_PTR_LSB +: IDX_W];
                end
            end
            SQ_ISSUE: state_d = SQ_WAIT;
            SQ_WAIT: begin
                if (conv_done) begin
                    if (is_last) begin
                        state_d = (scan_q && loop_en) ? SQ_HOLD : SQ_IDLE;
                    end else begin
                        idx_d   = idx_q + IDX_W'(1);
                        state_d = SQ_ISSUE;
                    end
                end
            end
            SQ_HOLD: begin
                if (!loop_en) begin
                    state_d = SQ_IDLE;
                end else if (fifo_empty) begin
                    state_d = SQ_ISSUE;
                    idx_d   = '0;
                end
            end
            default: state_d = SQ_IDLE;
        endcase
    end

    // State, index and mode registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            idx_q   <= '0;
            scan_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            scan_q  <= scan_d;
        end
    end

    // Completion flag: cleared by accept, set on last push, cleared by a read.
    always_ff @(posedge clk) begin
        if (!rst_n)                   done_q <= 1'b0;
        else if (accept)              done_q <= 1'b0;
        else if (fifo_push && is_last) done_q <= 1'b1;
        else if (pop_ok)              done_q <= 1'b0;
    end

    assign conv_start = (state_q == SQ_ISSUE);
    assign idx        = idx_q;
    assign fifo_push  = (state_q == SQ_WAIT) && conv_done;
    assign fifo_clr   = accept;
    assign scan_done  = done_q;
    assign busy       = (state_q != SQ_IDLE);

    // R6: the start strobe lasts one cycle.
    a_r6_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);
    // R6: a non-final completion launches the next conversion at once.
    a_r6_next_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_WAIT && conv_done && !is_last) |=> conv_start);
    // R3: while a conversion runs, index and state hold regardless of commands.
    a_r3_run_undisturbed: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_WAIT && !conv_done) |=> ($stable(idx_q) && state_q == SQ_WAIT));
    // R4: a single run ends idle with the flag raised.
    a_r4_single_once: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_WAIT && conv_done && !scan_q) |=> (!busy && scan_done));
    // R8: a read with no completion in the same cycle drops the flag.
    a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_ok && !(fifo_push && is_last)) |=> !scan_done);
    // R9: no restart while unread results remain.
    a_r9_hold_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_HOLD && !fifo_empty) |=> !conv_start);
endmodule

// File: rtl/conv_sequencer.sv
// Top of the conversion instruction sequencer. Connects the instruction
// store, the run controller and the result queue. The queue depth equals
// the number of stored instructions, so a full scan always fits.
module conv_sequencer
    import cseq_pkg::*;
#(
    parameter int NUM_SETUP = 8,
    parameter int CH_W      = 2,
    parameter int RES_W     = 24
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               reg_wr,
    input  logic [$clog2(NUM_SETUP/2+1)-1:0]   reg_addr,
    input  logic [2*SETUP_W-1:0]               reg_wdata,
    output logic [2*SETUP_W-1:0]               reg_rdata,
    input  logic                               cmd_valid,
    input  logic [CMD_W-1:0]                   cmd_code,
    output logic                               conv_start,
    output logic [CH_W-1:0]                    conv_chan,
    output logic [SETUP_W-CH_W-1:0]            conv_opts,
    input  logic                               conv_done,
    input  logic [RES_W-1:0]                   conv_data,
    input  logic                               rd_en,
    output logic [RES_W-1:0]                   rd_data,
    output logic                               fifo_empty,
    output logic                               scan_done,
    output logic                               busy
);
    localparam int IDX_W  = $clog2(NUM_SETUP);
    localparam int ADDR_W = $clog2(NUM_SETUP/2 + 1);

    logic [IDX_W-1:0]   run_idx, depth_m1;
    logic [SETUP_W-1:0] cur_setup;
    logic               loop_en, push, clr;

    cseq_setup_store #(
        .NUM_SETUP (NUM_SETUP),
        .ADDR_W    (ADDR_W),
        .IDX_W     (IDX_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .sel_idx   (run_idx),
        .sel_setup (cur_setup),
        .depth_m1  (depth_m1),
        .loop_en   (loop_en)
    );

    cseq_fsm #(
        .IDX_W (IDX_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_code   (cmd_code),
        .depth_m1   (depth_m1),
        .loop_en    (loop_en),
        .conv_done  (conv_done),
        .fifo_empty (fifo_empty),
        .rd_en      (rd_en),
        .conv_start (conv_start),
        .idx        (run_idx),
        .fifo_push  (push),
        .fifo_clr   (clr),
        .scan_done  (scan_done),
        .busy       (busy)
    );

    cseq_fifo #(
        .DEPTH (NUM_SETUP),
        .W     (RES_W)
    ) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .push  (push),
        .pop   (rd_en),
        .din   (conv_data),
        .dout  (rd_data),
        .empty (fifo_empty)
    );

    assign conv_chan = cur_setup[CH_W-1:0];
    assign conv_opts = cur_setup[SETUP_W-1:CH_W];
endmodule

// File: tb/conv_sequencer_tb.sv
// Bench for conv_sequencer: a behavioural queue-based model stepped on
// each rising edge and compared with the outputs on each falling edge,
// plus directed checks for each requirement.
module conv_sequencer_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr;
    logic [2:0]  reg_addr;
    logic [23:0] reg_wdata;
    logic [23:0] reg_rdata;
    logic        cmd_valid;
    logic [7:0]  cmd_code;
    logic        conv_start;
    logic [1:0]  conv_chan;
    logic [9:0]  conv_opts;
    logic        conv_done;
    logic [23:0] conv_data;
    logic        rd_en;
    logic [23:0] rd_data;
    logic        fifo_empty;
    logic        scan_done;
    logic        busy;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 0;

    conv_sequencer u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_valid(cmd_valid),
        .cmd_code(cmd_code), .conv_start(conv_start), .conv_chan(conv_chan),
        .conv_opts(conv_opts), .conv_done(conv_done), .conv_data(conv_data),
        .rd_en(rd_en), .rd_data(rd_data), .fifo_empty(fifo_empty),
        .scan_done(scan_done), .busy(busy)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [11:0] sval(input int k);
        return {10'(k * 37 + 5), 2'((k - 1) % 4)};
    endfunction

    // ---------------- reference model ----------------
    int          m_st;
    int          m_idx;
    bit          m_scan, m_done, m_loop;
    int          m_depth;
    logic [11:0] m_set [8];
    logic [23:0] m_q [$];
    int          osz;
    bit          acc, psh, lst;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_idx = 0; m_scan = 0; m_done = 0; m_loop = 0; m_depth = 0;
            for (int i = 0; i < 8; i++) m_set[i] = '0;
            m_q.delete();
        end else begin
            osz = m_q.size(); acc = 0; psh = 0; lst = 0;
            case (m_st)
                0: if (cmd_valid && cmd_code[7] && cmd_code[2:0] == 3'd0) begin
                       acc = 1; m_q.delete(); m_done = 0; m_scan = cmd_code[6];
                       m_idx = m_scan ? 0 : int'(cmd_code[5:3]); m_st = 1;
                   end
                1: m_st = 2;
                2: if (conv_done) begin
                       psh = 1; lst = !m_scan || (m_idx == m_depth);
                       if (lst) m_st = (m_scan && m_loop) ? 3 : 0;
                       else begin m_idx++; m_st = 1; end
                   end
                default: if (!m_loop) m_st = 0;
                         else if (osz == 0) begin m_st = 1; m_idx = 0; end
            endcase
            if (!acc && rd_en && osz > 0) begin void'(m_q.pop_front()); m_done = 0; end
            if (psh) begin m_q.push_back(conv_data); if (lst) m_done = 1; end
            if (reg_wr) begin
                if (reg_addr < 3'd4) begin
                    m_set[2*int'(reg_addr)]   = reg_wdata[11:0];
                    m_set[2*int'(reg_addr)+1] = reg_wdata[23:12];
                end else if (reg_addr == 3'd4) begin
                    m_depth = int'(reg_wdata[2:0]); m_loop = reg_wdata[3];
                end
            end
        end
    end

    // Per-cycle comparison of the outputs against the model.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R3 busy", busy, m_st != 0);
            chk("R6 conv_start", conv_start, m_st == 1);
            if (m_st == 1) begin
                chk("R2 conv_chan", conv_chan, m_set[m_idx][1:0]);
                chk("R2 conv_opts", conv_opts, m_set[m_idx][11:2]);
            end
            chk("R7 fifo_empty", fifo_empty, m_q.size() == 0);
            if (m_q.size() > 0) chk("R5 rd_data order", rd_data, m_q[0]);
            chk("R8 scan_done", scan_done, m_done);
        end
    end

    // ---------------- conversion engine model ----------------
    int          cd_cnt = 0;
    int          seq = 0;
    logic [23:0] cd_val;
    always @(negedge clk) begin
        conv_done <= 1'b0;
        if (!rst_n) begin
            cd_cnt = 0;
        end else begin
            if (cd_cnt > 0) begin
                cd_cnt--;
                if (cd_cnt == 0) begin conv_done <= 1'b1; conv_data <= cd_val; end
            end
            if (conv_start) begin
                cd_cnt = 1 + (seq % 3);
                cd_val = {conv_chan, conv_opts, 12'(seq)};
                seq++;
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr_reg(input logic [2:0] a, input logic [23:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic send_cmd(input logic [7:0] c);
        cmd_valid = 1; cmd_code = c;
        @(negedge clk);
        cmd_valid = 0;
    endtask

    task automatic wait_idle();
        for (int t = 0; t < 3000 && busy; t++) @(negedge clk);
    endtask

    task automatic wait_done();
        for (int t = 0; t < 3000 && !scan_done; t++) @(negedge clk);
    endtask

    task automatic drain(output int n);
        n = 0;
        while (!fifo_empty && n < 20) begin
            rd_en = 1; @(negedge clk); n++;
        end
        rd_en = 0;
    endtask

    task automatic finish_run();
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !finished) begin
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    // ---------------- directed sequence ----------------
    initial begin
        int n;
        rst_n = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
        cmd_valid = 0; cmd_code = 0; rd_en = 0; conv_done = 0; conv_data = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R10 busy", busy, 0);
        chk("R10 empty", fifo_empty, 1);
        chk("R10 done", scan_done, 0);
        reg_addr = 3'd4; #1 chk("R10 ctrl zero", reg_rdata, 0);
        reg_addr = 3'd1; #1 chk("R10 pair zero", reg_rdata, 0);

        // R1: load four instruction words and read them back.
        for (int a = 0; a < 4; a++) wr_reg(3'(a), {sval(2*a+2), sval(2*a+1)});
        for (int a = 0; a < 4; a++) begin
            reg_addr = 3'(a); #1;
            chk("R1 pair readback", reg_rdata, {sval(2*a+2), sval(2*a+1)});
        end
        wr_reg(3'd4, 24'hFFFFF3);
        reg_addr = 3'd4; #1 chk("R1 ctrl readback", reg_rdata, 24'h3);

        // R3: commands with go bit clear or reserved bits set are ignored.
        send_cmd(8'h40);
        chk("R3 go bit clear ignored", busy, 0);
        send_cmd(8'hA1);
        chk("R3 reserved bits ignored", busy, 0);

        // R4: single run of instruction 5.
        send_cmd(8'hA0);
        chk("R6 accept busy", busy, 1);
        chk("R6 start after accept", conv_start, 1);
        wait_idle();
        chk("R4 flag raised", scan_done, 1);
        chk("R4 channel of result", rd_data[23:22], sval(5)[1:0]);
        chk("R4 options of result", rd_data[21:12], sval(5)[11:2]);
        drain(n);
        chk("R4 one entry", n, 1);
        chk("R8 cleared by read", scan_done, 0);

        // R7: a read on an empty queue changes nothing.
        rd_en = 1; @(negedge clk); rd_en = 0;
        chk("R7 empty read empty", fifo_empty, 1);
        chk("R7 empty read flag", scan_done, 0);

        // R5: scan of four instructions, with a command sent mid-run (R3).
        send_cmd(8'hC0);
        @(negedge clk);
        send_cmd(8'hA0);
        wait_idle();
        chk("R5 flag after scan", scan_done, 1);
        chk("R5 first result is instruction 1", rd_data[21:12], sval(1)[11:2]);
        drain(n);
        chk("R5 four results", n, 4);

        // R5 boundary: full-length scan fills the queue exactly.
        wr_reg(3'd4, 24'h7);
        send_cmd(8'hC0);
        wait_idle();
        chk("R5 full scan flag", scan_done, 1);
        rd_en = 1; @(negedge clk); @(negedge clk); rd_en = 0;
        chk("R8 cleared after reads", scan_done, 0);
        chk("R7 third oldest shown", rd_data[21:12], sval(3)[11:2]);
        // R7: new command discards the six unread entries.
        send_cmd(8'hA0);
        wait_idle();
        drain(n);
        chk("R7 stale entries discarded", n, 1);

        // R9: continuous two-instruction scan.
        wr_reg(3'd4, 24'h9);
        send_cmd(8'hC0);
        wait_done();
        repeat (6) @(negedge clk);
        chk("R9 waiting busy", busy, 1);
        chk("R9 no restart before drain", conv_start, 0);
        chk("R9 results held", fifo_empty, 0);
        drain(n);
        chk("R9 two results", n, 2);
        wait_done();
        chk("R9 restarted scan completes", scan_done, 1);
        wr_reg(3'd4, 24'h1);
        wait_idle();
        chk("R9 stops when bit cleared", busy, 0);
        drain(n);
        chk("R9 second cycle results", n, 2);

        // R4: single run of instruction 8 (pointer 7).
        send_cmd(8'hB8);
        wait_idle();
        chk("R4 last instruction opts", rd_data[21:12], sval(8)[11:2]);
        drain(n);
        chk("R4 single entry again", n, 1);

        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule